// File: doc/BRIEF.md
# I2C Target with High-Speed Mode Entry

This block is the target end of a two-wire serial bus. A fast system clock oversamples the bus clock and data lines. The block finds START, repeated START and STOP conditions. It shifts in the first byte of each transfer and compares its upper seven bits with a fixed device address. On a match it acknowledges. In a write it then delivers each received byte on a one-cycle strobe. In a read it serialises bytes taken from a parallel input.

The block also watches for the high-speed master code, any first byte of the form 00001xxx. It never acknowledges that code, but it raises a mode flag. The flag persists through any number of repeated STARTs and falls only at a STOP, so logic nearby can retune timing-related settings. The bus data line is driven in open-drain fashion through an enable output. The bus clock is never stretched.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset the data-line pull-down enable, the high-speed flag and the receive strobe are all low.
- R2: A falling data edge while the clock is high is a START. A rising data edge while the clock is high is a STOP. After a STOP, bits clocked without a new START get no acknowledge.
- R3: The first byte after START is sent MSB first. Bits 7..1 are the address and bit 0 is the direction (0 = master writes, 1 = master reads). With the default address 7'h4C, the bytes 0x98 and 0x99 are acknowledged by holding SDA low for the whole high time of the 9th clock.
- R4: A first byte whose address differs from the device address gets no acknowledge. The bytes that follow are not delivered, until the next START.
- R5: The general-call byte 0x00 and any first byte of the form 11110xxx (10-bit prefix) are never acknowledged.
- R6: In a write, each received byte appears on rx_data_o, MSB first as received, together with a one-cycle rx_valid_o pulse. The block acknowledges each byte.
- R7: In a read, tx_data_i is captured, with a one-cycle tx_load_o pulse, at the end of the address acknowledge and at the end of each master ACK. It is sent MSB first, and SDA changes only while SCL is low.
- R8: A master NACK (SDA high on the 9th clock of a read byte) ends the read. SDA stays released until the next START or STOP.
- R9: A first byte matching 00001xxx is not acknowledged and sets hs_mode_o.
- R10: hs_mode_o stays set across repeated STARTs. Transfers after them use the same address and data framing as before.
- R11: A STOP clears hs_mode_o.
- R12: A repeated START, even in the middle of a byte, restarts address reception without a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| tx_data_i | input | 8 | Byte to return in a read |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| rx_data_o | output | 8 | Last byte written by the master |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_load_o | output | 1 | One-cycle strobe when tx_data_i is captured |
| hs_mode_o | output | 1 | High-speed mode flag |

## Verification
The assertions check on every cycle the properties that need no knowledge of the transfer. The drive enable moves only while the synchronised clock is low, or in response to a bus condition. A STOP releases the line and clears the high-speed flag, which never falls for any other reason. The flag rises with no acknowledge driven, and the receive and load strobes last one cycle. Address matching and rejection of reserved bytes, data values and bit order, the end of a read after a NACK, and persistence of the flag across repeated STARTs depend on whole byte sequences. Only the bench's directed transfers show those.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [4:0] HS_CODE_PFX  = 5'b00001;
  localparam logic [4:0] TEN_BIT_PFX  = 5'b11110;
  localparam logic [6:0] GEN_CALL_ADR = 7'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    // idle bus is high: reset to 1 so no false START after reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges only count as conditions while SCL stays high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_hs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_s_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_load_o,
  output logic              hs_mode_o
);
  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              rw_q, mack_q, oe_q, hs_q, rx_valid_q, tx_load_q;
  logic [BYTE_W-1:0] rx_data_q;

  logic byte_full, is_hs_code, is_reserved, addr_hit;

  assign byte_full   = (cnt_q == CNT_W'(BYTE_W));
  assign is_hs_code  = (shift_q[7:3] == HS_CODE_PFX);
  assign is_reserved = (shift_q[7:1] == GEN_CALL_ADR) || (shift_q[7:3] == TEN_BIT_PFX);
  assign addr_hit    = (shift_q[7:1] == DEV_ADDR) && !is_reserved;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      oe_q       <= 1'b0;
      hs_q       <= 1'b0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      tx_load_q  <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      tx_load_q  <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        hs_q    <= 1'b0;
        oe_q    <= 1'b0;
        cnt_q   <= '0;
      end else if (start_i) begin
        // START and repeated START both restart address reception
        state_q <= ST_ADDR;
        oe_q    <= 1'b0;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i && !byte_full) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i && byte_full) begin
              cnt_q <= '0;
              if (is_hs_code) begin
                hs_q    <= 1'b1;
                state_q <= ST_SKIP;
              end else if (addr_hit) begin
                rw_q    <= shift_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rw_q) begin
                shift_q   <= tx_data_i;
                tx_load_q <= 1'b1;
                oe_q      <= ~tx_data_i[BYTE_W-1];
                state_q   <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i && !byte_full) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_s_i};
              cnt_q   <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i && byte_full) begin
              cnt_q      <= '0;
              rx_data_q  <= shift_q;
              rx_valid_q <= 1'b1;
              oe_q       <= 1'b1;
              state_q    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i && !byte_full) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall_i) begin
              if (byte_full) begin
                oe_q    <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_RD_ACK;
              end else if (cnt_q != '0) begin
                shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                oe_q    <= ~shift_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                shift_q   <= tx_data_i;
                tx_load_q <= 1'b1;
                oe_q      <= ~tx_data_i[BYTE_W-1];
                state_q   <= ST_RD;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_load_o  = tx_load_q;
  assign hs_mode_o  = hs_q;
endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2c_hs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_load_o,
  output logic              hs_mode_o
);
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_s, stop_s;

  i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_cond_det u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_s),
    .stop_o    (stop_s)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_s),
    .stop_i    (stop_s),
    .sda_s_i   (sda_s),
    .tx_data_i (tx_data_i),
    .sda_oe_o  (sda_oe_o),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid_o),
    .tx_load_o (tx_load_o),
    .hs_mode_o (hs_mode_o)
  );
endmodule

// File: rtl/i2c_hs_target_chk.sv
module i2c_hs_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_s,
  input logic stop_s,
  input logic sda_oe_o,
  input logic hs_mode_o,
  input logic rx_valid_o,
  input logic tx_load_o
);
  p_oe_moves_scl_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(start_s) || $past(stop_s)));

  p_stop_releases_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_s |=> !sda_oe_o);

  p_hs_rise_noack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> !sda_oe_o);

  p_hs_fall_only_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_mode_o) |-> $past(stop_s));

  p_hs_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_s |=> !hs_mode_o);

  p_rx_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_load_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o);
endmodule

bind i2c_hs_target i2c_hs_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s     (scl_s),
  .start_s   (start_s),
  .stop_s    (stop_s),
  .sda_oe_o  (sda_oe_o),
  .hs_mode_o (hs_mode_o),
  .rx_valid_o(rx_valid_o),
  .tx_load_o (tx_load_o)
);

// File: tb/i2c_hs_target_tb_top.sv
module i2c_hs_target_tb_top;
  localparam int Q = 20;  // quarter bit in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       sda_oe, rx_valid, tx_load, hs_mode;
  logic [7:0] rx_data;
  wire        sda_bus = m_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  int rx_cnt = 0;
  int ld_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_hs_target dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .tx_data_i (tx_data),
    .sda_oe_o  (sda_oe),
    .rx_data_o (rx_data),
    .rx_valid_o(rx_valid),
    .tx_load_o (tx_load),
    .hs_mode_o (hs_mode)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_data;
    end
    if (tx_load) ld_cnt <= ld_cnt + 1;
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;  // also serves as repeated START
    m_sda = 1'b1; wcyc(Q);
    m_scl = 1'b1; wcyc(Q);
    m_sda = 1'b0; wcyc(Q);
    m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wcyc(Q);
    m_scl = 1'b1; wcyc(Q);
    m_sda = 1'b1; wcyc(Q);
  endtask

  task automatic bus_bit(input bit b);
    m_sda = b;    wcyc(Q);
    m_scl = 1'b1; wcyc(2*Q);
    m_scl = 1'b0; wcyc(Q);
  endtask

  // clock one high phase, sampling SDA early and late
  task automatic bus_sample(output bit s1, output bit s2);
    wcyc(Q);
    m_scl = 1'b1; wcyc(2);
    s1 = sda_bus; wcyc(2*Q-4);
    s2 = sda_bus; wcyc(2);
    m_scl = 1'b0; wcyc(Q);
  endtask

  task automatic bus_send(input logic [7:0] b, output bit acked);
    bit s1, s2;
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    m_sda = 1'b1;
    bus_sample(s1, s2);
    acked = !s1 && !s2;
  endtask

  task automatic bus_recv(input bit give_ack, output logic [7:0] d, output bit steady);
    bit s1, s2;
    steady = 1'b1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bus_sample(s1, s2);
      d[i] = s1;
      if (s1 != s2) steady = 1'b0;
    end
    bus_bit(!give_ack);
    m_sda = 1'b1;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
    chk(hs_mode == 1'b0, "R1 hs_mode", int'(hs_mode), 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
  endtask

  task automatic t_write;
    bit a;
    int c0 = rx_cnt;
    bus_start;
    bus_send(8'h98, a); chk(a, "R3 address ack", int'(a), 1);
    bus_send(8'hA5, a); chk(a, "R6 data ack", int'(a), 1);
    chk(rx_cnt == c0 + 1 && rx_last == 8'hA5, "R6 byte 1", int'(rx_last), 'hA5);
    bus_send(8'h3C, a);
    chk(rx_cnt == c0 + 2 && rx_last == 8'h3C, "R6 byte 2", int'(rx_last), 'h3C);
    bus_stop; wcyc(Q);
    chk(sda_oe == 1'b0, "R2 released after stop", int'(sda_oe), 0);
  endtask

  task automatic t_wrong_addr;
    bit a;
    int c0 = rx_cnt;
    bus_start;
    bus_send(8'hA4, a); chk(!a, "R4 foreign address nack", int'(a), 0);
    bus_send(8'h11, a); chk(!a, "R4 later byte nack", int'(a), 0);
    chk(rx_cnt == c0, "R4 nothing delivered", rx_cnt - c0, 0);
    bus_stop; wcyc(Q);
  endtask

  task automatic t_reserved;
    bit a;
    bus_start; bus_send(8'h00, a); chk(!a, "R5 general call nack", int'(a), 0);
    bus_stop; wcyc(Q);
    bus_start; bus_send(8'hF0, a); chk(!a, "R5 ten-bit prefix nack", int'(a), 0);
    bus_stop; wcyc(Q);
  endtask

  task automatic t_stop_idle;
    bit a;
    int c0 = rx_cnt;
    m_scl = 1'b0; wcyc(Q);
    bus_send(8'h98, a); chk(!a, "R2 no start no ack", int'(a), 0);
    bus_send(8'h55, a);
    chk(rx_cnt == c0, "R2 idle ignores data", rx_cnt - c0, 0);
    m_scl = 1'b1; wcyc(Q);
  endtask

  task automatic t_read;
    bit a, st;
    logic [7:0] d;
    int l0 = ld_cnt;
    tx_data = 8'h96;
    bus_start;
    bus_send(8'h99, a); chk(a, "R3 read address ack", int'(a), 1);
    tx_data = 8'h5A;
    bus_recv(1'b1, d, st);
    chk(d == 8'h96, "R7 first read byte", int'(d), 'h96);
    chk(st, "R7 SDA steady while SCL high", int'(st), 1);
    tx_data = 8'h00;
    bus_recv(1'b0, d, st);
    chk(d == 8'h5A, "R7 second read byte", int'(d), 'h5A);
    chk(ld_cnt == l0 + 2, "R7 load strobes", ld_cnt - l0, 2);
    bus_recv(1'b0, d, st);
    chk(d == 8'hFF, "R8 released after nack", int'(d), 'hFF);
    chk(ld_cnt == l0 + 2, "R8 no load after nack", ld_cnt - l0, 2);
    bus_stop; wcyc(Q);
  endtask

  task automatic t_hs;
    bit a;
    int c0 = rx_cnt;
    bus_start;
    bus_send(8'h0B, a); chk(!a, "R9 master code nack", int'(a), 0);
    chk(hs_mode, "R9 hs set", int'(hs_mode), 1);
    bus_start;
    chk(hs_mode, "R10 hs kept over Sr", int'(hs_mode), 1);
    bus_send(8'h98, a); chk(a, "R10 address ack in hs", int'(a), 1);
    bus_send(8'h77, a);
    chk(a && rx_cnt == c0 + 1 && rx_last == 8'h77, "R10 data in hs", int'(rx_last), 'h77);
    bus_start;
    bus_send(8'h98, a); chk(a && hs_mode, "R10 second Sr", int'(hs_mode), 1);
    bus_stop; wcyc(Q);
    chk(!hs_mode, "R11 stop clears hs", int'(hs_mode), 0);
  endtask

  task automatic t_rstart;
    bit a, st;
    logic [7:0] d;
    bus_start;
    bus_send(8'h98, a);
    bus_send(8'h12, a);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_start;
    tx_data = 8'hC3;
    bus_send(8'h99, a); chk(a, "R12 ack after mid-byte Sr", int'(a), 1);
    bus_recv(1'b0, d, st);
    chk(d == 8'hC3, "R12 read after Sr", int'(d), 'hC3);
    bus_stop; wcyc(Q);
  endtask

  initial begin
    wcyc(5);
    t_reset;
    rst_n = 1'b1;
    wcyc(10);
    t_reset;
    t_write;
    t_wrong_addr;
    t_reserved;
    t_stop_idle;
    t_read;
    t_hs;
    t_rstart;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule